// File: doc/BRIEF.md
# Dual-Modulus 47/48 Prescaler

This block divides a fast input clock by either 47 or 48, chosen by a one-bit modulus select. It is a synchronous behavioural model built from two counters. A core counter normally divides by three. Its wrap pulse advances a 4-bit stage counter, which walks through sixteen slots per division cycle. That gives forty-eight input edges per cycle. When the select is low, a mode decoder watches the stage value. In the slot where the stage holds binary 1110, it flips the core to divide-by-two. The stage therefore swallows one input edge, and the cycle shortens to 47.

A pulse-swallow divider uses the block as its front stage. It changes the modulus between output cycles to build larger integer ratios. The select is captured only when the stage wraps from all ones to zero, so a cycle never mixes ratios. While reset is held, the captured select tracks the input. The output is the stage's most significant bit, a registered square wave with one rising edge per division cycle. The stage width is a parameter. With STAGE_BITS = B, the two ratios are 3·2^B and 3·2^B − 1.

Top module: `dm_prescaler`

## Requirements
- R1: While rst is high, div_out is 0 and the core and stage counters are 0. After rst falls, the first rising edge of div_out comes on the 24th rising clock edge (3·2^(B−1)).
- R2: With the captured modulus at 1 (mod_sel high), every slot of the core counter lasts 3 input edges, so rising edges of div_out are 48 input edges apart.
- R3: With the captured modulus at 0, the slot in which the stage holds 1110 lasts 2 input edges and all others last 3, so rising edges of div_out are 47 input edges apart (45 + 2).
- R4: The shortened slot falls only in stage state 1110, inside the high half of div_out. div_out is therefore high for 23 edges in the 47 mode and 24 edges in the 48 mode, and low for 24 edges in both.
- R5: mod_sel is captured only on the clock edge where the stage wraps from 1111 to 0000. A change of mod_sel at any other time, including a short pulse, has no effect on the cycle in progress. A value set just after a rising edge of div_out first governs the interval that starts at the next rising edge.
- R6: While rst is high, the captured modulus follows mod_sel, so the first division cycle after reset already uses the selected ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel | input | 1 | Modulus select: 1 divides by 48, 0 by 47 |
| div_out | output | 1 | Divided output, stage MSB, one rising edge per cycle |

## Verification
The bench builds the block with the default STAGE_BITS of 4. At that width a single division cycle is only 47 or 48 clocks long. Dozens of cycles with an arbitrary modulus sequence therefore fit in a few thousand clocks. The bench can also check every rise-to-rise interval, and the high and low halves, against the one-cycle capture latency. The small width also makes the first-edge timing after reset short enough to measure exactly. A mid-cycle pulse on the select can be placed before the wrap point to show that it is ignored.

// File: rtl/dm_prescaler_pkg.sv
package dm_prescaler_pkg;

  typedef enum logic {
    CORE_DIV3 = 1'b0,
    CORE_DIV2 = 1'b1
  } core_mode_e;

  localparam int unsigned CORE_CNT_W = 2;

endpackage

// File: rtl/dm_core23.sv
module dm_core23
  import dm_prescaler_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  core_mode_e            mode,
  output logic [CORE_CNT_W-1:0] cnt,
  output logic                  tick
);

  logic [CORE_CNT_W-1:0] last_val;

  always_comb begin
    last_val = (mode == CORE_DIV2) ? CORE_CNT_W'(1) : CORE_CNT_W'(2);
    tick     = (cnt == last_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CORE_CNT_W'(1);
    end
  end

endmodule

// File: rtl/dm_stage_ctr.sv
module dm_stage_ctr #(
  parameter int unsigned BITS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [BITS-1:0] q,
  output logic            wrap
);

  localparam logic [BITS-1:0] TOP = {BITS{1'b1}};

  assign wrap = adv && (q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (adv) begin
      q <= q + BITS'(1);
    end
  end

endmodule

// File: rtl/dm_mode_dec.sv
module dm_mode_dec
  import dm_prescaler_pkg::*;
#(
  parameter int unsigned BITS = 4
) (
  input  logic [BITS-1:0] stage,
  input  logic            mod_held,
  output core_mode_e      mode
);

  localparam logic [BITS-1:0] SWALLOW_STATE = {{(BITS-1){1'b1}}, 1'b0};

  logic hit;

  always_comb begin
    hit  = (stage == SWALLOW_STATE) && !mod_held;
    mode = hit ? CORE_DIV2 : CORE_DIV3;
  end

endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler
  import dm_prescaler_pkg::*;
#(
  parameter int unsigned STAGE_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_sel,
  output logic div_out
);

  localparam int unsigned MSB = STAGE_BITS - 1;

  core_mode_e            core_mode;
  logic [CORE_CNT_W-1:0] core_cnt;
  logic                  core_tick;
  logic [STAGE_BITS-1:0] stage_q;
  logic                  stage_wrap;
  logic                  mod_held;

  dm_core23 u_core (
    .clk  (clk),
    .rst  (rst),
    .mode (core_mode),
    .cnt  (core_cnt),
    .tick (core_tick)
  );

  dm_stage_ctr #(.BITS(STAGE_BITS)) u_stage (
    .clk  (clk),
    .rst  (rst),
    .adv  (core_tick),
    .q    (stage_q),
    .wrap (stage_wrap)
  );

  dm_mode_dec #(.BITS(STAGE_BITS)) u_dec (
    .stage    (stage_q),
    .mod_held (mod_held),
    .mode     (core_mode)
  );

  always_ff @(posedge clk) begin
    if (rst || stage_wrap) begin
      mod_held <= mod_sel;
    end
  end

  assign div_out = stage_q[MSB];

endmodule

// File: rtl/dm_prescaler_chk.sv
module dm_prescaler_chk #(
  parameter int unsigned STAGE_BITS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  div_out,
  input logic [1:0]            core_cnt,
  input logic [STAGE_BITS-1:0] stage_q,
  input logic                  mod_held
);

  localparam logic [STAGE_BITS-1:0] SW = {{(STAGE_BITS-1){1'b1}}, 1'b0};
  localparam logic [STAGE_BITS-1:0] TOPV = {STAGE_BITS{1'b1}};

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!div_out && stage_q == '0 && core_cnt == 2'd0));

  // R2
  full_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_held && core_cnt == 2'd1) |=> (core_cnt == 2'd2));

  // R3
  swallow_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_held && stage_q == SW) |-> (core_cnt != 2'd2));

  // R4
  only_in_sw_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_q != SW && core_cnt == 2'd1) |=> (core_cnt == 2'd2));

  // R4
  stage_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stage_q) |-> ($past(core_cnt) != 2'd0));

  // R5
  mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_q != TOPV) |=> $stable(mod_held));

endmodule

bind dm_prescaler dm_prescaler_chk #(.STAGE_BITS(STAGE_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .div_out  (div_out),
  .core_cnt (core_cnt),
  .stage_q  (stage_q),
  .mod_held (mod_held)
);

// File: tb/test_dm_prescaler.sv
`timescale 1ns/1ps
module test_dm_prescaler;

  localparam int SB   = 4;
  localparam int FULL = 3 * (1 << SB);
  localparam int HALF = FULL / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_sel = 1'b1;
  logic div_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dm_prescaler #(.STAGE_BITS(SB)) i_dm_prescaler (
    .clk     (clk),
    .rst     (rst),
    .mod_sel (mod_sel),
    .div_out (div_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling clock edge; counts rising clock edges until div_out
  // shows the requested transition at a falling edge.
  task automatic wait_edge(input logic to_high, output int n);
    logic p;
    p = div_out;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (div_out == to_high && p != to_high) break;
      p = div_out;
      if (n > 4 * FULL) break;
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1;
    mod_sel = m;
    repeat (4) begin
      @(negedge clk);
      check("R1 reset out", int'(div_out), 0);
    end
    rst = 1'b0;
  endtask

  initial begin
    int n;
    int prev_m;
    logic [7:0] lfsr;

    // R1 and R6: first edge timing after reset, both moduli
    do_reset(1'b1);
    wait_edge(1'b1, n);
    check("R1 first rise", n, HALF);
    wait_edge(1'b1, n);
    check("R6 first period mod1", n, FULL);

    do_reset(1'b0);
    wait_edge(1'b1, n);
    check("R1 first rise mod0", n, HALF);
    wait_edge(1'b1, n);
    check("R6 first period mod0", n, FULL - 1);

    // R2: steady divide by 48 with halves
    do_reset(1'b1);
    wait_edge(1'b1, n);
    for (int i = 0; i < 3; i++) begin
      wait_edge(1'b1, n);
      check("R2 period 48", n, FULL);
    end
    wait_edge(1'b0, n);
    check("R4 high mod1", n, HALF);
    wait_edge(1'b1, n);
    check("R4 low mod1", n, HALF);

    // R3: steady divide by 47 with halves
    do_reset(1'b0);
    wait_edge(1'b1, n);
    for (int i = 0; i < 3; i++) begin
      wait_edge(1'b1, n);
      check("R3 period 47", n, FULL - 1);
    end
    wait_edge(1'b0, n);
    check("R4 high mod0", n, HALF - 1);
    wait_edge(1'b1, n);
    check("R4 low mod0", n, HALF);

    // R5: pulse on mod_sel before the wrap point is ignored
    do_reset(1'b1);
    wait_edge(1'b1, n);
    wait_edge(1'b1, n);
    n = 0;
    repeat (5) begin @(posedge clk); n++; end
    @(negedge clk); mod_sel = 1'b0;
    repeat (3) begin @(posedge clk); n++; end
    @(negedge clk); mod_sel = 1'b1;
    begin
      int m;
      wait_edge(1'b1, m);
      n = n + m;
    end
    check("R5 glitch ignored", n, FULL);
    wait_edge(1'b1, n);
    check("R5 after glitch", n, FULL);

    // R5: sweep of modulus sequences; value set after rise i governs
    // the interval that starts at rise i+1
    do_reset(1'b1);
    wait_edge(1'b1, n);
    prev_m = 1;
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      logic m;
      m = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mod_sel = m;
      wait_edge(1'b1, n);
      check("R5 sweep period", n, (prev_m != 0) ? FULL : FULL - 1);
      prev_m = int'(m);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule